// File: doc/BRIEF.md
# Bridge Legacy Range Routing Decoder

This block sits in the host-facing side of a virtual PCI-to-PCI bridge and steers each host memory or I/O request either to the secondary (graphics) bus or to the primary bus. It compares the request address with an I/O window and a set of memory windows. Each window is given as a base and a limit on plain input pins. An 8-bit bridge control register, written and read through a small configuration port, holds two routing switches. The legacy-display switch forwards the fixed display memory and I/O ranges to the secondary bus. The legacy-ISA switch takes the upper three quarters of every 1 KB I/O block out of the I/O window.

Requests arrive on a valid/ready stream and the decision leaves on a one-entry registered valid/ready stream. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the output payload holds still and no new request is accepted. A small responder models a master abort on the secondary bus. One cycle after the abort it returns all ones for a read, and for a write it reports that the data was dropped.

Top module: `bridge_route_decoder`

## Requirements
- R1: After reset the control register reads 00h. Bit 3 (legacy-display enable) and bit 2 (legacy-ISA enable) are read/write. Bits 7..4, 1 and 0 always read 0, and writes to them are ignored.
- R2: With bit 3 set, a memory request to any address from 0A0000h to 0BFFFFh inclusive is routed to the secondary bus with reason code 1 (legacy display).
- R3: With bit 3 set, an I/O request whose A[9:0] lies in 3B0h..3BBh or in 3C0h..3DFh is routed to the secondary bus with reason 1. A[15:10] is ignored, so every alias matches. 3BCh..3BFh and 3E0h do not match.
- R4: A legacy-display match routes to the secondary bus whatever the windows hold and whatever the value of bit 2.
- R5: With bit 3 clear, a request in a legacy display range goes to the primary bus (reason 0) unless it falls inside a window, in which case it goes to the secondary bus (reason 3).
- R6: With bit 2 clear, every I/O address with io_base <= A[15:0] <= io_limit goes to the secondary bus with reason 3. Addresses just outside either end go to the primary bus with reason 0.
- R7: With bit 2 set, an in-window I/O address with A[9:8] not equal to 00 goes to the primary bus with reason 2 (ISA exclusion). An in-window address with A[9:8] = 00 still goes to the secondary bus with reason 3.
- R8: A memory request inside any of the memory windows (base <= address <= limit, both ends inclusive) goes to the secondary bus with reason 3. Otherwise it goes to the primary bus with reason 0.
- R9: The decision appears on rsp_* in the cycle after acceptance. While rsp_valid is high and rsp_ready is low, the payload is held and req_ready is low.
- R10: A configuration write takes effect for requests accepted on later cycles. A request accepted on the same edge as the write uses the old register value.
- R11: A master abort read returns abort_rdata = all ones with abort_done one cycle later. A master abort write sets abort_wr_dropped with abort_done and returns abort_rdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| io_base | input | 16 | I/O window base (inclusive) |
| io_limit | input | 16 | I/O window limit (inclusive) |
| mem_base | input | NUM_MEM_WIN*32 | Memory window bases, window i in bits [32i+31:32i] |
| mem_limit | input | NUM_MEM_WIN*32 | Memory window limits (inclusive) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address (I/O uses bits 15:0) |
| rsp_valid | output | 1 | Decision valid |
| rsp_ready | input | 1 | Consumer ready for the decision |
| rsp_to_sec | output | 1 | 1 = secondary bus, 0 = primary bus |
| rsp_reason | output | 2 | 0 default, 1 legacy display, 2 ISA exclusion, 3 window |
| rsp_is_io | output | 1 | Copy of request type |
| rsp_is_write | output | 1 | Copy of request direction |
| rsp_addr | output | 32 | Copy of request address |
| abort_req | input | 1 | Master abort seen on the secondary bus |
| abort_is_write | input | 1 | Aborted transaction was a write |
| abort_done | output | 1 | Abort response valid |
| abort_rdata | output | 32 | Read data returned on an abort |
| abort_wr_dropped | output | 1 | Aborted write data was discarded |

## Verification
The assertions assume that the consumer may hold rsp_ready low for any number of cycles. They also assume that abort_req is a single-cycle pulse carrying a stable abort_is_write. The bench drives every input half a cycle away from the active edge and raises abort_req for one cycle at a time. It changes the window pins and the control register only while no request is in flight, so each decision depends only on the values in place at its acceptance edge. The one exception is the deliberate same-edge write check of R10.

// File: rtl/brd_pkg.sv
package brd_pkg;
  typedef enum logic [1:0] {
    RSN_DEFAULT = 2'd0,
    RSN_LEGACY  = 2'd1,
    RSN_ISA_EXC = 2'd2,
    RSN_WINDOW  = 2'd3
  } route_reason_e;

  localparam int unsigned CTRL_W      = 8;
  localparam int unsigned BIT_LEG_EN  = 3;
  localparam int unsigned BIT_ISA_EN  = 2;
  localparam logic [CTRL_W-1:0] CTRL_WR_MASK =
    CTRL_W'((1 << BIT_LEG_EN) | (1 << BIT_ISA_EN));
endpackage

// File: rtl/brd_ctrl_reg.sv
module brd_ctrl_reg
  import brd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  output logic              leg_en,
  output logic              isa_en
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (cfg_we) ctrl_q <= cfg_wdata & CTRL_WR_MASK;
  end

  assign cfg_rdata = ctrl_q & CTRL_WR_MASK;
  assign leg_en    = ctrl_q[BIT_LEG_EN];
  assign isa_en    = ctrl_q[BIT_ISA_EN];
endmodule

// File: rtl/brd_window.sv
module brd_window #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] base,
  input  logic [W-1:0] limit,
  output logic         hit
);
  // inclusive at both ends; base > limit gives an empty window
  assign hit = (addr >= base) && (addr <= limit);
endmodule

// File: rtl/brd_legacy_decode.sv
module brd_legacy_decode #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              is_io,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] FB_LO = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] FB_HI = ADDR_W'(32'h000B_FFFF);

  logic [9:0] low10;
  logic       mem_hit;
  logic       io_hit;

  assign low10   = addr[9:0];
  assign mem_hit = (addr >= FB_LO) && (addr <= FB_HI);
  // only A[9:0] decoded: ISA aliases fold onto the same ports
  assign io_hit  = ((low10 >= 10'h3B0) && (low10 <= 10'h3BB)) ||
                   ((low10 >= 10'h3C0) && (low10 <= 10'h3DF));
  assign hit     = is_io ? io_hit : mem_hit;
endmodule

// File: rtl/brd_abort_resp.sv
module brd_abort_resp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_req,
  input  logic              abort_is_write,
  output logic              abort_done,
  output logic [DATA_W-1:0] abort_rdata,
  output logic              abort_wr_dropped
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_done       <= 1'b0;
      abort_rdata      <= '0;
      abort_wr_dropped <= 1'b0;
    end else begin
      abort_done       <= abort_req;
      abort_rdata      <= (abort_req && !abort_is_write) ? '1 : '0;
      abort_wr_dropped <= abort_req && abort_is_write;
    end
  end
endmodule

// File: rtl/bridge_route_decoder.sv
module bridge_route_decoder
  import brd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned IO_W        = 16,
  parameter int unsigned NUM_MEM_WIN = 2,
  parameter int unsigned DATA_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [7:0]                    cfg_wdata,
  output logic [7:0]                    cfg_rdata,
  input  logic [IO_W-1:0]               io_base,
  input  logic [IO_W-1:0]               io_limit,
  input  logic [NUM_MEM_WIN*ADDR_W-1:0] mem_base,
  input  logic [NUM_MEM_WIN*ADDR_W-1:0] mem_limit,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_is_io,
  input  logic                          req_is_write,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic                          rsp_to_sec,
  output logic [1:0]                    rsp_reason,
  output logic                          rsp_is_io,
  output logic                          rsp_is_write,
  output logic [ADDR_W-1:0]             rsp_addr,
  input  logic                          abort_req,
  input  logic                          abort_is_write,
  output logic                          abort_done,
  output logic [DATA_W-1:0]             abort_rdata,
  output logic                          abort_wr_dropped
);
  logic                   leg_en, isa_en;
  logic                   leg_hit, io_win_hit, mem_hit, win_hit, isa_excl;
  logic [NUM_MEM_WIN-1:0] mem_hits;
  logic [IO_W-1:0]        io_addr;
  logic                   nxt_to_sec;
  route_reason_e          nxt_reason;
  logic                   accept;

  brd_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .leg_en(leg_en), .isa_en(isa_en)
  );

  brd_legacy_decode #(.ADDR_W(ADDR_W)) u_leg (
    .is_io(req_is_io), .addr(req_addr), .hit(leg_hit)
  );

  assign io_addr = req_addr[IO_W-1:0];

  brd_window #(.W(IO_W)) u_io_win (
    .addr(io_addr), .base(io_base), .limit(io_limit), .hit(io_win_hit)
  );

  for (genvar gi = 0; gi < NUM_MEM_WIN; gi++) begin : g_mem_win
    brd_window #(.W(ADDR_W)) u_mem_win (
      .addr (req_addr),
      .base (mem_base [gi*ADDR_W +: ADDR_W]),
      .limit(mem_limit[gi*ADDR_W +: ADDR_W]),
      .hit  (mem_hits[gi])
    );
  end

  assign mem_hit  = |mem_hits;
  assign win_hit  = req_is_io ? io_win_hit : mem_hit;
  assign isa_excl = isa_en && req_is_io && io_win_hit && (io_addr[9:8] != 2'b00);

  // priority: legacy display, ISA exclusion, window, default
  always_comb begin
    if (leg_en && leg_hit) begin
      nxt_to_sec = 1'b1;
      nxt_reason = RSN_LEGACY;
    end else if (isa_excl) begin
      nxt_to_sec = 1'b0;
      nxt_reason = RSN_ISA_EXC;
    end else if (win_hit) begin
      nxt_to_sec = 1'b1;
      nxt_reason = RSN_WINDOW;
    end else begin
      nxt_to_sec = 1'b0;
      nxt_reason = RSN_DEFAULT;
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         rsp_valid <= 1'b0;
    else if (req_ready) rsp_valid <= req_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_to_sec   <= 1'b0;
      rsp_reason   <= RSN_DEFAULT;
      rsp_is_io    <= 1'b0;
      rsp_is_write <= 1'b0;
      rsp_addr     <= '0;
    end else if (accept) begin
      rsp_to_sec   <= nxt_to_sec;
      rsp_reason   <= nxt_reason;
      rsp_is_io    <= req_is_io;
      rsp_is_write <= req_is_write;
      rsp_addr     <= req_addr;
    end
  end

  brd_abort_resp #(.DATA_W(DATA_W)) u_abort (
    .clk(clk), .rst_n(rst_n), .abort_req(abort_req),
    .abort_is_write(abort_is_write), .abort_done(abort_done),
    .abort_rdata(abort_rdata), .abort_wr_dropped(abort_wr_dropped)
  );
endmodule

// File: rtl/brd_checker.sv
module brd_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg_rdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_to_sec,
  input logic [1:0]        rsp_reason,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              abort_req,
  input logic              abort_is_write,
  input logic              abort_done,
  input logic [DATA_W-1:0] abort_rdata,
  input logic              abort_wr_dropped
);
  // R1
  ctrl_fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & 8'hF3) == 8'h00);

  // R9
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
                                   $stable(rsp_to_sec) && $stable(rsp_reason)));

  // R9
  stall_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R2
  legacy_goes_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_reason == 2'd1) |-> rsp_to_sec);

  // R7
  isa_goes_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_reason == 2'd2) |-> !rsp_to_sec);

  // R11
  abort_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && !abort_is_write) |=> (abort_done && (&abort_rdata) && !abort_wr_dropped));

  // R11
  abort_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && abort_is_write) |=> (abort_done && abort_wr_dropped && abort_rdata == '0));
endmodule

bind bridge_route_decoder brd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_to_sec(rsp_to_sec), .rsp_reason(rsp_reason), .rsp_addr(rsp_addr),
  .abort_req(abort_req), .abort_is_write(abort_is_write),
  .abort_done(abort_done), .abort_rdata(abort_rdata),
  .abort_wr_dropped(abort_wr_dropped)
);

// File: tb/bridge_route_decoder_tb.sv
`timescale 1ns/1ps
module bridge_route_decoder_tb;
  localparam int NW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] io_base = 16'h1000, io_limit = 16'h1FFF;
  logic [NW*32-1:0] mem_base  = {32'h000B_0000, 32'hE000_0000};
  logic [NW*32-1:0] mem_limit = {32'h000B_FFFF, 32'hE0FF_FFFF};
  logic        req_valid = 1'b0, req_ready, req_is_io = 1'b0, req_is_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_to_sec, rsp_is_io, rsp_is_write;
  logic [1:0]  rsp_reason;
  logic [31:0] rsp_addr;
  logic        abort_req = 1'b0, abort_is_write = 1'b0, abort_done, abort_wr_dropped;
  logic [31:0] abort_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bridge_route_decoder #(.NUM_MEM_WIN(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .io_base(io_base), .io_limit(io_limit),
    .mem_base(mem_base), .mem_limit(mem_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_io(req_is_io),
    .req_is_write(req_is_write), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_to_sec(rsp_to_sec),
    .rsp_reason(rsp_reason), .rsp_is_io(rsp_is_io), .rsp_is_write(rsp_is_write),
    .rsp_addr(rsp_addr), .abort_req(abort_req), .abort_is_write(abort_is_write),
    .abort_done(abort_done), .abort_rdata(abort_rdata),
    .abort_wr_dropped(abort_wr_dropped)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // send one request, check decision one cycle after acceptance
  task automatic route(input logic io, input logic [31:0] a, input logic exp_sec,
                       input logic [1:0] exp_rsn, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_is_io = io; req_addr = a; req_is_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, {tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk(rsp_to_sec === exp_sec && rsp_reason === exp_rsn, {tag, " route"},
        {29'd0, rsp_to_sec, rsp_reason}, {29'd0, exp_sec, exp_rsn});
  endtask

  task automatic t_reset();
    chk(cfg_rdata === 8'h00, "R1 reset value", {24'd0, cfg_rdata}, 32'h0);
    chk(rsp_valid === 1'b0 && abort_done === 1'b0, "R9 reset idle",
        {30'd0, rsp_valid, abort_done}, 32'h0);
  endtask

  task automatic t_cfg_reg();
    cfg_write(8'hFF);
    chk(cfg_rdata === 8'h0C, "R1 only bits 3,2 writable", {24'd0, cfg_rdata}, 32'h0C);
    cfg_write(8'hF3);
    chk(cfg_rdata === 8'h00, "R1 fixed bits ignored", {24'd0, cfg_rdata}, 32'h0);
  endtask

  task automatic t_legacy_mem();
    cfg_write(8'h08);
    route(1'b0, 32'h000A_0000, 1'b1, 2'd1, "R2 low end");
    route(1'b0, 32'h000B_FFFF, 1'b1, 2'd1, "R2 high end");
    route(1'b0, 32'h0009_FFFF, 1'b0, 2'd0, "R2 below");
    route(1'b0, 32'h000C_0000, 1'b0, 2'd0, "R2 above");
  endtask

  task automatic t_legacy_io();
    cfg_write(8'h08);
    route(1'b1, 32'h0000_03B0, 1'b1, 2'd1, "R3 3B0");
    route(1'b1, 32'h0000_03BB, 1'b1, 2'd1, "R3 3BB");
    route(1'b1, 32'h0000_03BC, 1'b0, 2'd0, "R3 3BC gap");
    route(1'b1, 32'h0000_03C0, 1'b1, 2'd1, "R3 3C0");
    route(1'b1, 32'h0000_03DF, 1'b1, 2'd1, "R3 3DF");
    route(1'b1, 32'h0000_03E0, 1'b0, 2'd0, "R3 3E0");
    route(1'b1, 32'h0000_F7C5, 1'b1, 2'd1, "R3 alias F7C5");
  endtask

  task automatic t_override();
    cfg_write(8'h0C);
    // 17B5: inside io window, A[9:8]=11 would be excluded by ISA mode
    route(1'b1, 32'h0000_17B5, 1'b1, 2'd1, "R4 legacy beats ISA and window");
    route(1'b0, 32'h000B_8000, 1'b1, 2'd1, "R4 legacy beats mem window");
  endtask

  task automatic t_legacy_off();
    cfg_write(8'h00);
    route(1'b0, 32'h000A_0000, 1'b0, 2'd0, "R5 mem to primary");
    route(1'b0, 32'h000B_8000, 1'b1, 2'd3, "R5 mem in window");
    route(1'b1, 32'h0000_03C0, 1'b0, 2'd0, "R5 io to primary");
    route(1'b1, 32'h0000_17C0, 1'b1, 2'd3, "R5 io alias in window");
  endtask

  task automatic t_io_window();
    cfg_write(8'h00);
    route(1'b1, 32'h0000_1000, 1'b1, 2'd3, "R6 base");
    route(1'b1, 32'h0000_1FFF, 1'b1, 2'd3, "R6 limit");
    route(1'b1, 32'h0000_1100, 1'b1, 2'd3, "R6 upper quarter with ISA off");
    route(1'b1, 32'h0000_0FFF, 1'b0, 2'd0, "R6 below base");
    route(1'b1, 32'h0000_2000, 1'b0, 2'd0, "R6 above limit");
  endtask

  task automatic t_isa();
    cfg_write(8'h04);
    route(1'b1, 32'h0000_1100, 1'b0, 2'd2, "R7 A98=01");
    route(1'b1, 32'h0000_13FF, 1'b0, 2'd2, "R7 A98=11");
    route(1'b1, 32'h0000_1050, 1'b1, 2'd3, "R7 A98=00");
    route(1'b1, 32'h0000_2100, 1'b0, 2'd0, "R7 outside window");
  endtask

  task automatic t_mem_window();
    cfg_write(8'h00);
    route(1'b0, 32'hE000_0000, 1'b1, 2'd3, "R8 win0 base");
    route(1'b0, 32'hE0FF_FFFF, 1'b1, 2'd3, "R8 win0 limit");
    route(1'b0, 32'hE100_0000, 1'b0, 2'd0, "R8 past win0");
    route(1'b0, 32'h000B_0000, 1'b1, 2'd3, "R8 win1 base");
  endtask

  task automatic t_backpressure();
    cfg_write(8'h00);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_is_io = 1'b0; req_addr = 32'hE000_0010;
    @(negedge clk);
    req_addr = 32'h0000_1234;  // second request, must wait
    chk(rsp_valid === 1'b1 && rsp_addr === 32'hE000_0010, "R9 first out",
        rsp_addr, 32'hE000_0010);
    chk(req_ready === 1'b0, "R9 ready low in stall", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk(rsp_addr === 32'hE000_0010 && rsp_to_sec === 1'b1, "R9 held in stall",
        rsp_addr, 32'hE000_0010);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_addr === 32'h0000_1234 && rsp_to_sec === 1'b0,
        "R9 second after drain", rsp_addr, 32'h0000_1234);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 empty after drain", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_cfg_timing();
    cfg_write(8'h00);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 8'h08;
    req_valid = 1'b1; req_is_io = 1'b0; req_addr = 32'h000A_0000;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk(rsp_to_sec === 1'b0 && rsp_reason === 2'd0, "R10 same edge uses old",
        {30'd0, rsp_reason}, 32'd0);
    route(1'b0, 32'h000A_0000, 1'b1, 2'd1, "R10 next request uses new");
  endtask

  task automatic t_abort();
    @(negedge clk); abort_req = 1'b1; abort_is_write = 1'b0;
    @(negedge clk); abort_req = 1'b0;
    chk(abort_done === 1'b1 && abort_rdata === 32'hFFFF_FFFF && abort_wr_dropped === 1'b0,
        "R11 read all ones", abort_rdata, 32'hFFFF_FFFF);
    @(negedge clk); abort_req = 1'b1; abort_is_write = 1'b1;
    @(negedge clk); abort_req = 1'b0;
    chk(abort_done === 1'b1 && abort_wr_dropped === 1'b1 && abort_rdata === 32'h0,
        "R11 write dropped", {31'd0, abort_wr_dropped}, 32'd1);
    @(negedge clk);
    chk(abort_done === 1'b0, "R11 done is one cycle", {31'd0, abort_done}, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_reg();
    t_legacy_mem();
    t_legacy_io();
    t_override();
    t_legacy_off();
    t_io_window();
    t_isa();
    t_mem_window();
    t_backpressure();
    t_cfg_timing();
    t_abort();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule